// File: doc/BRIEF.md
# Tracking-Arm Code Selector with Dither

This block picks the local spreading code that drives a correlator's tracking arm. Every clock it receives the early and late code chips as single bits, a 2-bit mode select and an epoch strobe. The strobe pulses once per epoch increment, where one epoch is 20 code periods. From these it forms one signed code value per cycle.

The four modes give the early code, the late code, a dithered code, or half the early-minus-late difference. The dithered code switches between early and late on every epoch strobe. The half difference can be +1, 0 or −1. A status output shows software whether the dither currently sits on the early or the late code.

The result is registered and appears one cycle after its inputs. It is presented as a sign-extended two's-complement value whose width is a parameter.

Top module: `trk_arm_code_sel`

## Requirements
- R1: With mode 2'b00 the output equals the early chip, where chip bit 0 means +1 and chip bit 1 means −1.
- R2: With mode 2'b01 the output equals the late chip, using the same bit-to-value mapping as R1.
- R3: With mode 2'b10 the output follows the early chip while the dither state is early, and the late chip while the dither state is late. The state used is the one held in the cycle the inputs were sampled.
- R4: The dither state inverts at the clock edge where epoch_stb is high, and holds at every other edge. dither_late shows it: 0 means early, 1 means late.
- R5: While rst_n is low, the dither state is early and the output is 0.
- R6: With mode 2'b11 the output is (early − late)/2. It is 0 when the chips are equal, +1 for early=0 and late=1, and −1 for early=1 and late=0.
- R7: In modes 2'b00, 2'b01 and 2'b10 the output is never 0. In no mode does it leave the range −1 to +1.
- R8: The dither state keeps inverting on epoch strobes while any other mode is selected.
- R9: The output changes exactly one clock edge after the inputs that produce it are sampled. It is OUT_W bits wide and sign-extended, so −1 reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| early_chip | input | 1 | Early code chip (0 = +1, 1 = −1) |
| late_chip | input | 1 | Late code chip (0 = +1, 1 = −1) |
| mode | input | 2 | Code selection mode |
| epoch_stb | input | 1 | One-cycle pulse per epoch increment |
| code_out | output | OUT_W | Registered signed code value |
| dither_late | output | 1 | Dither state, 1 = late code in use |

## Verification
The bench builds the block with OUT_W = 4. This makes the sign extension of −1 to 4'b1111 visible at the port, which the 2-bit default would hide. Epoch strobes are issued both inside and outside dither mode, so the bench can confirm that the dither phase found on entering dither mode comes from strobes seen earlier. Every early/late chip pair is driven in each mode, including the equal pairs that give zero in early-minus-late mode.

// File: rtl/trk_code_pkg.sv
package trk_code_pkg;

   typedef enum logic [1:0] {
      SEL_EARLY    = 2'b00,
      SEL_LATE     = 2'b01,
      SEL_DITHER   = 2'b10,
      SEL_HALFDIFF = 2'b11
   } trk_sel_e;

   localparam int VAL_W = 2;

   // chip bit 0 means +1, chip bit 1 means -1
   function automatic logic signed [VAL_W-1:0] chip_val(input logic b);
      return b ? -2'sd1 : 2'sd1;
   endfunction

endpackage

// File: rtl/trk_dither_state.sv
module trk_dither_state (
   input  logic clk,
   input  logic rst_n,
   input  logic epoch_stb,
   output logic on_late
);

   always_ff @(posedge clk) begin
      if (!rst_n) on_late <= 1'b0;
      else if (epoch_stb) on_late <= ~on_late;
   end

   // R4
   dither_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      epoch_stb |=> (on_late != $past(on_late)));

   // R4
   dither_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !epoch_stb |=> $stable(on_late));

endmodule

// File: rtl/trk_code_mux.sv
module trk_code_mux
   import trk_code_pkg::*;
(
   input  logic                    early_chip,
   input  logic                    late_chip,
   input  trk_sel_e                sel,
   input  logic                    on_late,
   output logic signed [VAL_W-1:0] val
);

   logic signed [VAL_W-1:0] early_v;
   logic signed [VAL_W-1:0] late_v;
   logic signed [VAL_W-1:0] half_diff;

   assign early_v = chip_val(early_chip);
   assign late_v  = chip_val(late_chip);

   // (early - late)/2 taken straight from the chip bits: equal gives 0
   always_comb begin
      if (early_chip == late_chip) half_diff = '0;
      else if (!early_chip)        half_diff = 2'sd1;
      else                         half_diff = -2'sd1;
   end

   always_comb begin
      unique case (sel)
         SEL_EARLY:    val = early_v;
         SEL_LATE:     val = late_v;
         SEL_DITHER:   val = on_late ? late_v : early_v;
         SEL_HALFDIFF: val = half_diff;
         default:      val = '0;
      endcase
   end

endmodule

// File: rtl/trk_arm_code_sel.sv
module trk_arm_code_sel
   import trk_code_pkg::*;
#(
   parameter int OUT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             early_chip,
   input  logic             late_chip,
   input  logic [1:0]       mode,
   input  logic             epoch_stb,
   output logic [OUT_W-1:0] code_out,
   output logic             dither_late
);

   localparam int EXT_W = OUT_W - VAL_W;

   if (OUT_W < VAL_W) begin : g_width_bad
      $error("trk_arm_code_sel: OUT_W must be at least 2");
   end

   logic                    on_late;
   logic signed [VAL_W-1:0] sel_val;
   logic [OUT_W-1:0]        ext_val;

   trk_dither_state u_dither (
      .clk       (clk),
      .rst_n     (rst_n),
      .epoch_stb (epoch_stb),
      .on_late   (on_late)
   );

   trk_code_mux u_mux (
      .early_chip (early_chip),
      .late_chip  (late_chip),
      .sel        (trk_sel_e'(mode)),
      .on_late    (on_late),
      .val        (sel_val)
   );

   if (EXT_W == 0) begin : g_narrow
      assign ext_val = sel_val;
   end else begin : g_wide
      assign ext_val = {{EXT_W{sel_val[VAL_W-1]}}, sel_val};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) code_out <= '0;
      else        code_out <= ext_val;
   end

   assign dither_late = on_late;

   // R7
   out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ($signed(code_out) >= -1 && $signed(code_out) <= 1));

   // R7
   nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != SEL_HALFDIFF) |=> (code_out != '0));

   // R1 R9
   early_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SEL_EARLY) |=>
         ($signed(code_out) == ($past(early_chip) ? -1 : 1)));

   // R6
   halfdiff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SEL_HALFDIFF && early_chip == late_chip) |=> (code_out == '0));

endmodule

// File: tb/sim_trk_arm_code_sel.sv
module sim_trk_arm_code_sel;

   localparam int OUT_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             early_chip = 1'b0;
   logic             late_chip = 1'b0;
   logic [1:0]       mode = 2'b00;
   logic             epoch_stb = 1'b0;
   logic [OUT_W-1:0] code_out;
   logic             dither_late;

   int total = 0;
   int bad = 0;

   typedef struct {
      int    code;
      bit    dl;
      string tag;
   } exp_t;

   exp_t sb[$];
   bit   m_late = 1'b0;

   always #5 clk = ~clk;

   trk_arm_code_sel #(.OUT_W(OUT_W)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .early_chip  (early_chip),
      .late_chip   (late_chip),
      .mode        (mode),
      .epoch_stb   (epoch_stb),
      .code_out    (code_out),
      .dither_late (dither_late)
   );

   function automatic int cv(input bit b);
      return b ? -1 : 1;
   endfunction

   // driver: inputs change 3 ns after a rising edge; expectation is queued
   task automatic drive(input bit e, input bit l, input bit [1:0] m,
                        input bit stb, input string tag);
      exp_t x;
      int   c;
      @(posedge clk);
      #3;
      early_chip = e; late_chip = l; mode = m; epoch_stb = stb;
      case (m)
         2'b00: c = cv(e);
         2'b01: c = cv(l);
         2'b10: c = m_late ? cv(l) : cv(e);
         default: c = (e == l) ? 0 : (e ? -1 : 1);
      endcase
      m_late = m_late ^ stb;
      x.code = c; x.dl = m_late; x.tag = tag;
      sb.push_back(x);
   endtask

   // monitor: compares 1 ns after each rising edge
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t x;
         x = sb.pop_front();
         total++;
         if ($signed(code_out) != x.code) begin
            bad++;
            $display("FAIL %s code_out: actual=%0d expected=%0d",
                     x.tag, $signed(code_out), x.code);
         end
         total++;
         if (dither_late != x.dl) begin
            bad++;
            $display("FAIL %s dither_late: actual=%0d expected=%0d",
                     x.tag, dither_late, x.dl);
         end
      end
   end

   initial begin
      #1_000_000;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #3;
      // R5: reset values
      total++;
      if (code_out != '0 || dither_late != 1'b0) begin
         bad++;
         $display("FAIL R5 reset: actual=%0d/%0d expected=0/0",
                  $signed(code_out), dither_late);
      end
      rst_n = 1'b1;

      // R1 with R9 sign extension
      drive(0, 1, 2'b00, 0, "R1 early +1");
      drive(1, 0, 2'b00, 0, "R1 early -1 R9");
      drive(1, 1, 2'b00, 0, "R1 early -1");
      // R2
      drive(0, 1, 2'b01, 0, "R2 late -1");
      drive(1, 0, 2'b01, 0, "R2 late +1");
      // R6 all pairs, R7 range
      drive(0, 0, 2'b11, 0, "R6 eq 0");
      drive(1, 1, 2'b11, 0, "R6 eq 0");
      drive(0, 1, 2'b11, 0, "R6 +1");
      drive(1, 0, 2'b11, 0, "R6 -1 R7");
      // R3 dither on early, then strobe R4
      drive(1, 0, 2'b10, 0, "R3 dither early");
      drive(0, 1, 2'b10, 1, "R3 R4 strobe cycle uses early");
      drive(0, 1, 2'b10, 0, "R3 dither late");
      drive(1, 0, 2'b10, 0, "R3 R4 hold late");
      drive(1, 0, 2'b10, 1, "R4 toggle back");
      drive(1, 0, 2'b10, 0, "R3 early again");
      // R8 strobes outside dither mode
      drive(0, 0, 2'b00, 1, "R8 strobe in early mode");
      drive(1, 1, 2'b11, 0, "R8 hold in halfdiff");
      drive(0, 1, 2'b10, 0, "R8 R3 enter dither late");
      drive(0, 0, 2'b01, 1, "R8 strobe in late mode");
      drive(0, 1, 2'b10, 0, "R8 R3 enter dither early");
      // R7 non-zero in all single-code modes with equal chips
      drive(0, 0, 2'b10, 0, "R7 dither +1");
      drive(1, 1, 2'b01, 0, "R7 late -1");
      // R4 repeated strobes
      for (int i = 0; i < 6; i++) drive(i[0], ~i[0], 2'b10, 1, "R4 back-to-back");
      drive(0, 0, 2'b00, 0, "R9 settle");
      @(posedge clk);
      #3;
      // R5 reset again after activity
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      total++;
      if (code_out != '0 || dither_late != 1'b0) begin
         bad++;
         $display("FAIL R5 re-reset: actual=%0d/%0d expected=0/0",
                  $signed(code_out), dither_late);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule